// File: doc/BRIEF.md
# Ethernet MAC Host Register Bank

This block is the set of host-visible control and status registers for a simple byte-wide Ethernet MAC. A host processor reaches it through a byte-wide, Wishbone-style slave port that has address, write data, read data, write enable, strobe and acknowledge. Behind the port the block keeps the 48-bit station address that the receive path matches frames against. It also keeps the transmit frame length, a command register holding the start-transmit and start-receive requests, and a per-direction interrupt enable. It drives all of these straight to the MAC core.

From the core it takes the transmitter-ready flag, the receive-valid flag and the length of the last received frame. The host reads these back as a status byte and as a receive length. The receive length shares its address pair with the transmit length, and the direction of the access picks between them. An interrupt output is raised while an enabled completion condition holds. Start requests clear themselves once the core signals, by dropping the matching flag, that it has taken them. The register window is eleven bytes wide and begins at `BASE_ADDR` (0x5F5 by default).

Top module: `eth_mac_host_regs`

## Requirements
- R1: After reset the acknowledge is low. A cycle with strobe high and acknowledge low is an access. It raises the acknowledge for exactly the next cycle, whatever the address. The read data is zero in every cycle without acknowledge.
- R2: Station address bytes are written at offsets 5..10 from the base (0x5FA..0x5FF). The byte at 0x5FA drives bits 47:40 of the station address output and the byte at 0x5FF drives bits 7:0. The output resets to zero and changes only on such a write.
- R3: A read of any station address byte returns 0x00.
- R4: A write at 0x5F6 loads transmit length bits 10:8 from write data bits 2:0; the upper five data bits are dropped. A write at 0x5F7 loads bits 7:0. Reads at 0x5F6 and 0x5F7 return {5'b0, receive length 10:8} and receive length 7:0, and leave the transmit length untouched. The transmit length resets to zero.
- R5: A read at 0x5F9 returns {6'b0, receive-valid, transmit-ready}, sampled in the access cycle. A write there changes no register.
- R6: The command register at 0x5F8 resets to 0x00. Write data bit 0 sets the start-transmit output and bit 1 sets the start-receive output. A read returns {6'b0, start-receive, start-transmit}.
- R7: A set start bit clears at the first clock edge that samples its flag (transmit-ready for transmit, receive-valid for receive) low when the previous edge sampled it high. A command write in that same cycle takes priority.
- R8: The interrupt enable register at 0x5F5 resets to 0x00. It stores write data bits 1:0, and a read returns them with bits 7:2 zero.
- R9: The interrupt output equals (transmit-ready AND enable bit 0) OR (receive-valid AND enable bit 1), following the inputs in the same cycle for as long as the condition holds.
- R10: Accesses to addresses outside 0x5F5..0x5FF are acknowledged, return 0x00 on reads and change nothing on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_adr_i | input | ADDR_W | Byte address |
| bus_dat_i | input | 8 | Write data |
| bus_dat_o | output | 8 | Read data, valid with acknowledge |
| bus_we_i | input | 1 | Write enable (high write, low read) |
| bus_stb_i | input | 1 | Access strobe |
| bus_ack_o | output | 1 | Access acknowledge |
| station_addr_o | output | 48 | Receive station address to the MAC core |
| tx_len_o | output | LEN_W | Transmit frame length to the MAC core |
| tx_start_o | output | 1 | Start-transmit request |
| rx_start_o | output | 1 | Start-receive request |
| tx_ready_i | input | 1 | Transmitter ready for a new frame |
| rx_valid_i | input | 1 | Received frame complete and valid |
| rx_len_i | input | LEN_W | Length of the received frame |
| irq_o | output | 1 | Interrupt request |

## Verification
The station address is loaded with six distinct byte values, so a reversed or shifted byte order shows as a mismatch. The length pair is written with the upper five bits of the high byte set and is read back with a different receive length present. This separates a write-enable mix-up from a masking fault. The flags and enables are stepped through each combination, and each start bit is cleared separately by its own flag falling, which exposes a crossed flag or a missing priority. A random phase then strobes the window and its two neighbouring addresses with strobes sometimes held over several cycles. A behavioural model checks every output on every clock throughout.

// File: rtl/eth_mac_host_regs.sv
module eth_mac_host_regs #(
  parameter int              ADDR_W    = 11,
  parameter int              LEN_W     = 11,
  parameter int              MAC_BYTES = 6,
  parameter logic [10:0]     BASE_ADDR = 11'h5F5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_adr_i,
  input  logic [7:0]            bus_dat_i,
  output logic [7:0]            bus_dat_o,
  input  logic                  bus_we_i,
  input  logic                  bus_stb_i,
  output logic                  bus_ack_o,
  output logic [8*MAC_BYTES-1:0] station_addr_o,
  output logic [LEN_W-1:0]      tx_len_o,
  output logic                  tx_start_o,
  output logic                  rx_start_o,
  input  logic                  tx_ready_i,
  input  logic                  rx_valid_i,
  input  logic [LEN_W-1:0]      rx_len_i,
  output logic                  irq_o
);
  localparam int HI_W     = LEN_W - 8;
  localparam int A_IE     = int'(BASE_ADDR);
  localparam int A_LEN_HI = A_IE + 1;
  localparam int A_LEN_LO = A_IE + 2;
  localparam int A_CMD    = A_IE + 3;
  localparam int A_STAT   = A_IE + 4;
  localparam int A_MAC    = A_IE + 5;

  logic       ack_q;
  logic [7:0] dat_q;
  logic [7:0] rd_val;
  logic [1:0] ie_q;
  logic       txs_q, rxs_q;
  logic       tr_q, rv_q;
  logic [LEN_W-1:0] tx_len_q;
  logic [7:0] mac_q [MAC_BYTES];

  wire access = bus_stb_i & ~ack_q;
  wire wr     = access & bus_we_i;
  wire rd     = access & ~bus_we_i;

  wire hit_ie  = bus_adr_i == ADDR_W'(A_IE);
  wire hit_lhi = bus_adr_i == ADDR_W'(A_LEN_HI);
  wire hit_llo = bus_adr_i == ADDR_W'(A_LEN_LO);
  wire hit_cmd = bus_adr_i == ADDR_W'(A_CMD);
  wire hit_st  = bus_adr_i == ADDR_W'(A_STAT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= access;
      dat_q <= rd ? rd_val : 8'h00;
    end

  always_comb begin
    rd_val = 8'h00;
    if (hit_ie)  rd_val = {6'b0, ie_q};
    if (hit_lhi) rd_val = {{(8-HI_W){1'b0}}, rx_len_i[LEN_W-1:8]};
    if (hit_llo) rd_val = rx_len_i[7:0];
    if (hit_cmd) rd_val = {6'b0, rxs_q, txs_q};
    if (hit_st)  rd_val = {6'b0, rx_valid_i, tx_ready_i};
  end

  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                       mac_q[g] <= 8'h00;
      else if (wr && bus_adr_i == ADDR_W'(A_MAC + g))   mac_q[g] <= bus_dat_i;
    assign station_addr_o[8*(MAC_BYTES-1-g) +: 8] = mac_q[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_len_q <= '0;
      ie_q     <= 2'b00;
    end else if (wr) begin
      if (hit_lhi) tx_len_q[LEN_W-1:8] <= bus_dat_i[HI_W-1:0];
      if (hit_llo) tx_len_q[7:0]       <= bus_dat_i;
      if (hit_ie)  ie_q                <= bus_dat_i[1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tr_q  <= 1'b0;
      rv_q  <= 1'b0;
      txs_q <= 1'b0;
      rxs_q <= 1'b0;
    end else begin
      tr_q <= tx_ready_i;
      rv_q <= rx_valid_i;
      if (wr && hit_cmd) begin
        txs_q <= bus_dat_i[0];
        rxs_q <= bus_dat_i[1];
      end else begin
        if (tr_q && !tx_ready_i) txs_q <= 1'b0;
        if (rv_q && !rx_valid_i) rxs_q <= 1'b0;
      end
    end

  assign bus_ack_o  = ack_q;
  assign bus_dat_o  = dat_q;
  assign tx_len_o   = tx_len_q;
  assign tx_start_o = txs_q;
  assign rx_start_o = rxs_q;
  assign irq_o      = (tx_ready_i & ie_q[0]) | (rx_valid_i & ie_q[1]);
endmodule

// File: rtl/eth_mac_host_regs_chk.sv
module eth_mac_host_regs_chk #(
  parameter int          ADDR_W    = 11,
  parameter int          LEN_W     = 11,
  parameter int          MAC_BYTES = 6,
  parameter logic [10:0] BASE_ADDR = 11'h5F5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      bus_adr_i,
  input logic [7:0]             bus_dat_o,
  input logic                   bus_we_i,
  input logic                   bus_stb_i,
  input logic                   bus_ack_o,
  input logic [8*MAC_BYTES-1:0] station_addr_o,
  input logic [LEN_W-1:0]       tx_len_o,
  input logic                   tx_start_o,
  input logic                   tx_ready_i,
  input logic                   rx_valid_i,
  input logic                   irq_o
);
  localparam int LO = int'(BASE_ADDR);
  localparam int HI = LO + 4 + MAC_BYTES;

  wire in_win = (int'(bus_adr_i) >= LO) && (int'(bus_adr_i) <= HI);

  assert_ack_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb_i && !bus_ack_o |=> bus_ack_o);
  assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack_o |=> !bus_ack_o);
  assert_dat_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_o |-> bus_dat_o == 8'h00);
  assert_mac_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(station_addr_o) |-> $past(bus_stb_i && bus_we_i && !bus_ack_o));
  assert_len_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_len_o) |-> $past(bus_stb_i && bus_we_i && !bus_ack_o));
  assert_status_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack_o && $past(!bus_we_i && int'(bus_adr_i) == LO + 4)
      |-> bus_dat_o == {6'b0, $past(rx_valid_i), $past(tx_ready_i)});
  assert_tx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_start_o) |-> ($past(!tx_ready_i) ||
      $past(bus_stb_i && bus_we_i && !bus_ack_o && int'(bus_adr_i) == LO + 3)));
  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (tx_ready_i || rx_valid_i));
  assert_oor_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack_o && $past(!in_win) |-> bus_dat_o == 8'h00);
endmodule

bind eth_mac_host_regs eth_mac_host_regs_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAC_BYTES(MAC_BYTES), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_adr_i(bus_adr_i), .bus_dat_o(bus_dat_o),
  .bus_we_i(bus_we_i), .bus_stb_i(bus_stb_i), .bus_ack_o(bus_ack_o),
  .station_addr_o(station_addr_o), .tx_len_o(tx_len_o), .tx_start_o(tx_start_o),
  .tx_ready_i(tx_ready_i), .rx_valid_i(rx_valid_i), .irq_o(irq_o)
);

// File: tb/eth_mac_host_regs_tb_top.sv
`timescale 1ns/100ps
module eth_mac_host_regs_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [10:0] adr = '0;
  logic [7:0]  wdat = '0;
  logic        we = 0, stb = 0;
  logic        tx_ready = 0, rx_valid = 0;
  logic [10:0] rx_len = '0;
  logic [7:0]  rdat;
  logic        ack, txs, rxs, irq;
  logic [47:0] mac;
  logic [10:0] txlen;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eth_mac_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_adr_i(adr), .bus_dat_i(wdat), .bus_dat_o(rdat),
    .bus_we_i(we), .bus_stb_i(stb), .bus_ack_o(ack), .station_addr_o(mac),
    .tx_len_o(txlen), .tx_start_o(txs), .rx_start_o(rxs), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_len_i(rx_len), .irq_o(irq));

  // behavioural reference model
  int    m_mac [6];
  int    m_len, m_dat;
  bit    m_ack, m_txs, m_rxs, m_ie0, m_ie1, m_ptr, m_prv;
  string m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mac[i]) m_mac[i] = 0;
      m_len = 0; m_dat = 0; m_ack = 0; m_txs = 0; m_rxs = 0;
      m_ie0 = 0; m_ie1 = 0; m_ptr = 0; m_prv = 0; m_tag = "R1";
    end else begin
      bit acc, cmdw;
      int a;
      acc = stb && !m_ack;
      a = int'(adr);
      cmdw = acc && we && a == 'h5F8;
      m_dat = 0; m_tag = "R1";
      if (acc && !we) begin
        case (a)
          'h5F5: begin m_dat = {m_ie1, m_ie0}; m_tag = "R8"; end
          'h5F6: begin m_dat = rx_len >> 8;    m_tag = "R4"; end
          'h5F7: begin m_dat = rx_len & 'hFF;  m_tag = "R4"; end
          'h5F8: begin m_dat = {m_rxs, m_txs}; m_tag = "R6"; end
          'h5F9: begin m_dat = {rx_valid, tx_ready}; m_tag = "R5"; end
          default: m_tag = (a >= 'h5FA && a <= 'h5FF) ? "R3" : "R10";
        endcase
      end
      if (acc && we) begin
        if (a >= 'h5FA && a <= 'h5FF) m_mac[a - 'h5FA] = wdat;
        if (a == 'h5F6) m_len = (m_len & 'hFF) | ((wdat & 7) << 8);
        if (a == 'h5F7) m_len = (m_len & 'h700) | wdat;
        if (a == 'h5F5) begin m_ie0 = wdat[0]; m_ie1 = wdat[1]; end
      end
      if (cmdw) begin m_txs = wdat[0]; m_rxs = wdat[1]; end
      else begin
        if (m_ptr && !tx_ready) m_txs = 0;
        if (m_prv && !rx_valid) m_rxs = 0;
      end
      m_ptr = tx_ready; m_prv = rx_valid;
      m_ack = acc;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint m_station();
    longint s = 0;
    for (int i = 0; i < 6; i++) s = (s << 8) | m_mac[i];
    return s;
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    check("R1 ack", ack, m_ack);
    check(m_tag, rdat, m_dat);
    check("R2 station", mac, m_station());
    check("R4 txlen", txlen, m_len);
    check("R6/R7 tx_start", txs, m_txs);
    check("R6/R7 rx_start", rxs, m_rxs);
    check("R9 irq", irq, (tx_ready & m_ie0) | (rx_valid & m_ie1));
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic acc(input bit w, input int a, input int d, output logic [7:0] r);
    tick();
    stb = 1; we = w; adr = 11'(a); wdat = 8'(d);
    tick();
    r = rdat;
    stb = 0; we = 0;
  endtask

  initial begin
    logic [7:0] r;
    tick(); tick();
    rst_n = 1;
    tick();
    check("R1 reset ack", ack, 0);
    check("R2 reset station", mac, 0);
    check("R4 reset txlen", txlen, 0);
    check("R6 reset starts", {rxs, txs}, 0);
    acc(0, 'h5F8, 0, r); check("R6 reset cmd read", r, 0);
    acc(0, 'h5F5, 0, r); check("R8 reset ie read", r, 0);

    for (int i = 0; i < 6; i++) acc(1, 'h5FA + i, 'h11 * (i + 1), r);
    tick(); check("R2 byte order", mac, 48'h112233445566);
    acc(0, 'h5FC, 0, r); check("R3 station read zero", r, 0);

    acc(1, 'h5F6, 'hFD, r); acc(1, 'h5F7, 'hEA, r);
    tick(); check("R4 txlen 1514", txlen, 1514);
    rx_len = 11'h3A5;
    acc(0, 'h5F6, 0, r); check("R4 rxlen hi", r, 'h03);
    acc(0, 'h5F7, 0, r); check("R4 rxlen lo", r, 'hA5);
    check("R4 txlen kept on read", txlen, 1514);

    tx_ready = 1;
    acc(0, 'h5F9, 0, r); check("R5 status tx", r, 'h01);
    rx_valid = 1;
    acc(0, 'h5F9, 0, r); check("R5 status both", r, 'h03);
    acc(1, 'h5F9, 'hFF, r);
    acc(0, 'h5F8, 0, r); check("R5 status write ignored", r, 0);

    acc(1, 'h5F5, 'hFF, r);
    acc(0, 'h5F5, 0, r); check("R8 ie readback", r, 'h03);
    tick(); check("R9 irq both", irq, 1);
    acc(1, 'h5F5, 'h01, r);
    tx_ready = 0; tick(); check("R9 irq masked rx", irq, 0);
    tx_ready = 1; tick(); check("R9 irq tx", irq, 1);

    acc(1, 'h5F8, 'h03, r);
    acc(0, 'h5F8, 0, r); check("R6 cmd readback", r, 'h03);
    check("R6 starts", {rxs, txs}, 2'b11);
    tx_ready = 0; tick();
    check("R7 tx cleared", txs, 0); check("R7 rx kept", rxs, 1);
    acc(0, 'h5F8, 0, r); check("R7 cmd pending rx", r, 'h02);
    rx_valid = 0; tick(); check("R7 rx cleared", rxs, 0);

    acc(1, 'h5F4, 'hFF, r); acc(1, 'h600, 'hFF, r);
    acc(0, 'h5F4, 0, r); check("R10 read outside", r, 0);
    check("R10 ack outside", ack, 1);
    acc(0, 'h5F5, 0, r); check("R10 ie untouched", r, 'h01);
    check("R10 station untouched", mac, 48'h112233445566);

    tick(); stb = 1; adr = 11'h5F9;
    for (int i = 0; i < 4; i++) tick();
    stb = 0;

    for (int i = 0; i < 600; i++) begin
      tick();
      stb      = ($urandom % 3) != 0;
      we       = $urandom % 2;
      adr      = 11'('h5F4 + ($urandom % 13));
      wdat     = 8'($urandom);
      rx_len   = 11'($urandom);
      if ($urandom % 4 == 0) tx_ready = ~tx_ready;
      if ($urandom % 4 == 0) rx_valid = ~rx_valid;
    end
    stb = 0;
    tick(); tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule